// File: doc/BRIEF.md
# Sector Check-Code Syndrome Classifier

This block takes two 3-byte check codes for one 256-byte flash sector, the one read back from the medium and the one recomputed from the data as read, and decides what went wrong. It forms a 22-bit syndrome by XOR-ing the two codes, counts its set bits and sorts the outcome into four classes: clean, one flipped data bit (with the byte address and bit index of the flip), one flipped bit inside the stored code, or an error beyond single-bit repair.

A controller pulses `start` with both codes on the inputs. One clock later the class and location appear, `done` is high for that one cycle, and the result then holds until the next strobe. The controller uses the location to toggle the bad bit in its buffer; that repair is not part of this block.

Top module: `nand_syn_top`

## Requirements
- R1: While and after reset, before any strobe, `status` is 2'b00, `err_byte` and `err_bit` are zero and `done` is low.
- R2: The result appears and `done` is high in the cycle after a clock edge that samples `start` high, for one cycle per strobe; back-to-back strobes give back-to-back results, and without a strobe all outputs hold their values.
- R3: When the two codes agree in every used bit, `status` is 2'b00 (clean).
- R4: The syndrome packs row parities 0..7 in code bits 7..0, row parities 8..15 in code bits 15..8 and column parities 0..5 in code bits 23..18; when exactly 11 syndrome bits are set, `status` is 2'b01 and `err_byte` bit k is row parity 2k+1 of the syndrome.
- R5: For status 2'b01, `err_bit` is {column parity 5, column parity 3, column parity 1} of the syndrome.
- R6: When exactly one syndrome bit is set, `status` is 2'b10 (the stored code is damaged, the data is good).
- R7: Any other syndrome weight (2 to 10, 12 to 22) gives `status` 2'b11 (uncorrectable).
- R8: Code bits 17..16 take no part in the syndrome; a difference there alone gives status 2'b00, and added to a single data-bit error still gives 2'b01.
- R9: `err_byte` and `err_bit` are zero whenever `status` is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe: classify the codes now on the inputs |
| stored_code | input | 24 | Check code read back from the medium |
| calc_code | input | 24 | Check code recomputed from the sector data |
| status | output | 2 | 00 clean, 01 data bit, 10 code bit, 11 uncorrectable |
| err_byte | output | 8 | Byte address of the flipped data bit |
| err_bit | output | 3 | Bit index within that byte |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Every result is due exactly one clock after the edge that sees the strobe, so the driver applies codes on a falling edge and pushes the expected class and location into a queue, and the monitor compares on the falling edge after the next rising edge, whenever `done` is high. On every falling edge without `done`, the monitor checks that the outputs still equal the last result, which covers the hold rule and catches a spurious or late `done`. Back-to-back strobes check that two results arrive on consecutive cycles in order.

// File: rtl/nand_syn_pkg.sv
package nand_syn_pkg;

    // Sector geometry: 2^ADDR_W bytes of 2^IDX_W bits each
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = 3;
    localparam int ROW_W   = 2 * ADDR_W;              // row parity pairs
    localparam int COL_W   = 2 * IDX_W;               // column parity pairs
    localparam int PAD_W   = 2;                       // unused low bits of the column byte
    localparam int CODE_W  = ROW_W + PAD_W + COL_W;   // 24
    localparam int SYN_W   = ROW_W + COL_W;           // 22
    localparam int CNT_W   = $clog2(SYN_W + 1);
    localparam int HIT_WT  = ADDR_W + IDX_W;          // weight of a single data-bit flip

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_DATA  = 2'b01,
        ST_CODE  = 2'b10,
        ST_BAD   = 2'b11
    } status_e;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } syn_t;

    typedef struct packed {
        status_e           st;
        logic [ADDR_W-1:0] byte_addr;
        logic [IDX_W-1:0]  bit_idx;
    } result_t;

    function automatic logic [CNT_W-1:0] weight_of(input syn_t s);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < SYN_W; i++) begin
            n = n + CNT_W'(s[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/nand_syn_form.sv
module nand_syn_form
    import nand_syn_pkg::*;
(
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output syn_t              syn
);
    localparam int COL_LO = ROW_W + PAD_W;

    logic [CODE_W-1:0] diff;

    always_comb begin
        diff    = code_a ^ code_b;
        syn.row = diff[ROW_W-1:0];
        syn.col = diff[CODE_W-1:COL_LO];
    end
endmodule

// File: rtl/nand_syn_class.sv
module nand_syn_class
    import nand_syn_pkg::*;
(
    input  syn_t    syn,
    output status_e st
);
    logic [CNT_W-1:0] wt;

    always_comb begin
        wt = weight_of(syn);
        if (wt == '0)
            st = ST_CLEAN;
        else if (wt == CNT_W'(HIT_WT))
            st = ST_DATA;
        else if (wt == CNT_W'(1))
            st = ST_CODE;
        else
            st = ST_BAD;
    end

    always_comb begin
        a_class_clean_r3: assert (!(wt == '0) || st == ST_CLEAN);
    end
endmodule

// File: rtl/nand_syn_locate.sv
module nand_syn_locate
    import nand_syn_pkg::*;
(
    input  syn_t              syn,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    // The odd member of each parity pair is set exactly when the
    // corresponding location bit of the flipped data bit is one.
    for (genvar k = 0; k < ADDR_W; k++) begin : g_row
        assign byte_addr[k] = syn.row[2*k+1];
    end
    for (genvar j = 0; j < IDX_W; j++) begin : g_col
        assign bit_idx[j] = syn.col[2*j+1];
    end
endmodule

// File: rtl/nand_syn_top.sv
module nand_syn_top
    import nand_syn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CODE_W-1:0]    stored_code,
    input  logic [CODE_W-1:0]    calc_code,
    output logic [1:0]           status,
    output logic [ADDR_W-1:0]    err_byte,
    output logic [IDX_W-1:0]     err_bit,
    output logic                 done
);
    syn_t              syn;
    status_e           st_nx;
    logic [ADDR_W-1:0] loc_byte;
    logic [IDX_W-1:0]  loc_bit;
    result_t           res_nx;
    result_t           res_q;
    logic              done_q;

    nand_syn_form u_form (
        .code_a (stored_code),
        .code_b (calc_code),
        .syn    (syn)
    );

    nand_syn_class u_class (
        .syn (syn),
        .st  (st_nx)
    );

    nand_syn_locate u_locate (
        .syn       (syn),
        .byte_addr (loc_byte),
        .bit_idx   (loc_bit)
    );

    always_comb begin
        res_nx.st = st_nx;
        if (st_nx == ST_DATA) begin
            res_nx.byte_addr = loc_byte;
            res_nx.bit_idx   = loc_bit;
        end else begin
            res_nx.byte_addr = '0;
            res_nx.bit_idx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '{st: ST_CLEAN, byte_addr: '0, bit_idx: '0};
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start)
                res_q <= res_nx;
        end
    end

    assign status   = res_q.st;
    assign err_byte = res_q.byte_addr;
    assign err_bit  = res_q.bit_idx;
    assign done     = done_q;

    localparam logic [CODE_W-1:0] USED_MASK =
        {{COL_W{1'b1}}, {PAD_W{1'b0}}, {ROW_W{1'b1}}};

    p_done_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

    p_loc_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (status != ST_DATA) |-> (err_byte == '0 && err_bit == '0));

    p_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_CLEAN) |->
            ($past((stored_code ^ calc_code) & USED_MASK) == '0));

    p_code_single_r6: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_CODE) |->
            ($countones($past((stored_code ^ calc_code) & USED_MASK)) == 1));

    p_data_weight_r4: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_DATA) |->
            ($countones($past((stored_code ^ calc_code) & USED_MASK)) == HIT_WT));
endmodule

// File: tb/nand_syn_top_test.sv
module nand_syn_top_test;
    import nand_syn_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [1:0]        st;
        logic [ADDR_W-1:0] byte_addr;
        logic [IDX_W-1:0]  bit_idx;
        string             tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [CODE_W-1:0]    stored_code = '0;
    logic [CODE_W-1:0]    calc_code = '0;
    logic [1:0]           status;
    logic [ADDR_W-1:0]    err_byte;
    logic [IDX_W-1:0]     err_bit;
    logic                 done;

    int checks = 0;
    int errors = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;
    exp_t sb[$];
    exp_t last;

    nand_syn_top uut (
        .clk (clk), .rst (rst), .start (start),
        .stored_code (stored_code), .calc_code (calc_code),
        .status (status), .err_byte (err_byte), .err_bit (err_bit), .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Place a 22-bit syndrome into the 24-bit code layout (R4, R8)
    function automatic logic [CODE_W-1:0] to_code(input logic [SYN_W-1:0] s);
        return {s[SYN_W-1:ROW_W], {PAD_W{1'b0}}, s[ROW_W-1:0]};
    endfunction

    // Syndrome left by one flipped data bit at byte a, bit b
    function automatic logic [SYN_W-1:0] hit_syn(input logic [ADDR_W-1:0] a,
                                                 input logic [IDX_W-1:0] b);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            s[2*k+1] = a[k];
            s[2*k]   = ~a[k];
        end
        for (int j = 0; j < IDX_W; j++) begin
            s[ROW_W+2*j+1] = b[j];
            s[ROW_W+2*j]   = ~b[j];
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic issue(input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b,
                         input logic [1:0] st, input logic [ADDR_W-1:0] ba,
                         input logic [IDX_W-1:0] bi, input string tag);
        exp_t e;
        @(negedge clk);
        stored_code = a;
        calc_code   = b;
        start       = 1'b1;
        e.st = st; e.byte_addr = ba; e.bit_idx = bi; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare results when due, hold checks otherwise (R2)
    initial begin
        last.st = 2'b00; last.byte_addr = '0; last.bit_idx = '0; last.tag = "R2";
        forever begin
            @(negedge clk);
            if (monitor_on) begin
                if (done) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R2", "unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(status == e.st, e.tag, "status", status, e.st);
                        check(err_byte == e.byte_addr, e.tag, "err_byte", err_byte, e.byte_addr);
                        check(err_bit == e.bit_idx, e.tag, "err_bit", err_bit, e.bit_idx);
                        last = e;
                    end
                end else begin
                    check(status == last.st && err_byte == last.byte_addr &&
                          err_bit == last.bit_idx, "R2", "hold",
                          {status, err_byte, err_bit},
                          {last.st, last.byte_addr, last.bit_idx});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CODE_W-1:0] base;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(status == 2'b00 && err_byte == 0 && err_bit == 0 && done == 0,
              "R1", "in reset", {status, err_byte, err_bit, done}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status == 2'b00 && err_byte == 0 && err_bit == 0 && done == 0,
              "R1", "after reset", {status, err_byte, err_bit, done}, 0);
        monitor_on = 1'b1;

        // R3: identical codes
        issue(24'hFFFFFF, 24'hFFFFFF, 2'b00, 0, 0, "R3");
        issue(24'h5A3C96, 24'h5A3C96, 2'b00, 0, 0, "R3");
        idle(2);

        // R4 / R5: single data-bit errors at several locations
        base = 24'hC3A517;
        issue(base, base ^ to_code(hit_syn(8'h00, 3'd0)), 2'b01, 8'h00, 3'd0, "R4");
        idle(1);
        issue(base, base ^ to_code(hit_syn(8'hFF, 3'd7)), 2'b01, 8'hFF, 3'd7, "R5");
        idle(1);
        issue(24'h123456, 24'h123456 ^ to_code(hit_syn(8'hA5, 3'd5)), 2'b01, 8'hA5, 3'd5, "R4");
        idle(1);
        issue(24'hFFFFFF, 24'hFFFFFF ^ to_code(hit_syn(8'h3C, 3'd2)), 2'b01, 8'h3C, 3'd2, "R5");
        idle(2);

        // R6: one flipped bit in the stored code
        issue(base, base ^ 24'h000001, 2'b10, 0, 0, "R6");
        idle(1);
        issue(base, base ^ 24'h008000, 2'b10, 0, 0, "R6");
        idle(1);
        issue(base, base ^ 24'h040000, 2'b10, 0, 0, "R6");
        idle(1);
        issue(base, base ^ 24'h800000, 2'b10, 0, 0, "R6");
        idle(2);

        // R8: pad bits ignored
        issue(base, base ^ 24'h030000, 2'b00, 0, 0, "R8");
        idle(1);
        issue(base, base ^ 24'h010000 ^ to_code(hit_syn(8'h81, 3'd6)), 2'b01, 8'h81, 3'd6, "R8");
        idle(2);

        // R7 / R9: other weights, location forced to zero
        issue(base, base ^ 24'h000003, 2'b11, 0, 0, "R7");
        idle(1);
        issue(base, base ^ 24'h0003FF, 2'b11, 0, 0, "R7");
        idle(1);
        issue(base, base ^ 24'h000FFF, 2'b11, 0, 0, "R9");
        idle(1);
        issue(base, ~base, 2'b11, 0, 0, "R7");
        idle(2);

        // R2: back-to-back strobes
        issue(base, base ^ to_code(hit_syn(8'h5A, 3'd1)), 2'b01, 8'h5A, 3'd1, "R2");
        issue(base, base ^ 24'h000100, 2'b10, 0, 0, "R2");
        issue(base, base, 2'b00, 0, 0, "R2");
        idle(4);

        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule